// File: doc/BRIEF.md
# Iterative Signed Fractional Multiplier

This execution unit serves a small 16-bit register-based coprocessor. On a start strobe it captures a signed 16-bit source operand and a signed 16-bit second operand that always comes from register 6. It forms their exact 32-bit two's-complement product and returns the upper 16 bits as the value to be written to a destination register. Alongside that value it reports a sign flag, a zero flag and a carry flag, and the carry takes product bit 15.

Only one 8x8 unsigned multiplier is built. The unit takes the magnitudes of both operands and feeds their four byte pairs through that multiplier one pass at a time, summing the shifted partial products. When the operand signs differ, it negates the sum at the end. A speed-configuration bit, captured at start, selects between a fast schedule of one cycle per pass (4 cycles) and a slow schedule of two cycles per pass (8 cycles). The unit raises a one-cycle done strobe and a write-enable. The write-enable is held low when the destination index is 4, so a result aimed at that register is discarded. Fetch, decode, register-file storage and the overflow flag are handled elsewhere, and this unit never alters the overflow flag.

Top module: `sfrac_mul_unit`

## Requirements
- R1: When done_o is high, result_o equals bits 31..16 of the exact signed 32-bit product of the captured operands, including the corner pairs 0x8000 x 0x8000 (result 0x4000) and 0x8000 x 0x7FFF (result 0xC000).
- R2: When done_o is high, flag_cy_o equals bit 15 of that product. Product bits 14..0 are not visible anywhere.
- R3: When done_o is high, flag_s_o equals result_o bit 15, and flag_z_o is 1 exactly when all 16 bits of result_o are 0.
- R4: With slow_cfg_i at 0 when the start is accepted (start_i high at a rising edge while idle), done_o is high during the 4th cycle after the accepting edge and low during the three cycles before it.
- R5: With slow_cfg_i at 1 when the start is accepted, done_o is high during the 8th cycle after the accepting edge and low during the seven cycles before it.
- R6: In the done cycle, wr_idx_o equals the destination index captured at start. wr_en_o is 1 for indices 0 to 3 and 5 to 15, and it is 0 when the index is 4.
- R7: done_o and wr_en_o are high for exactly one cycle per accepted start. wr_en_o is never high without done_o. result_o and all flags hold their values from one done cycle to the next.
- R8: A start_i pulse that arrives while an operation is running is ignored. This covers every rising edge from the accepting edge up to and including the edge that raises done_o. Such a pulse produces no extra done and does not change the result. A start in the done cycle itself is accepted.
- R9: The operands, destination index and speed bit are captured at the accepting edge. Later changes on those inputs affect neither the result nor the latency of the running operation.
- R10: While reset is asserted and after it is released, with no start, done_o, wr_en_o, result_o, wr_idx_o and all three flags read 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, sampled at each rising edge |
| src_op_i | input | 16 | Signed source operand |
| r6_op_i | input | 16 | Signed second operand (register 6 contents) |
| dst_idx_i | input | 4 | Destination register index |
| slow_cfg_i | input | 1 | Speed configuration: 0 fast, 1 slow |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | One-cycle register write-enable |
| wr_idx_o | output | 4 | Destination index for the write |
| result_o | output | 16 | Upper half of the signed product |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_cy_o | output | 1 | Carry flag (product bit 15) |

## Verification
Two events can fall in the same cycle: delivering a finished result and accepting the next start request. The bench provokes this by raising start_i with new operands during the done cycle of a running operation. It judges the first result in that cycle, and then it requires the second operation to finish exactly one full latency later with its own product. A related case holds start_i high through the edge that raises done_o. That start must be ignored, so the bench checks that only the original result appears and that no extra done strobe follows.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  localparam int FMUL_DW       = 16;
  localparam int FMUL_BW       = 8;
  localparam int FMUL_IW       = 4;
  localparam int FMUL_SKIP_IDX = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/fmul_byte_mul.sv
module fmul_byte_mul #(
  parameter int BW = fmul_pkg::FMUL_BW
) (
  input  logic [BW-1:0]   a_i,
  input  logic [BW-1:0]   b_i,
  output logic [2*BW-1:0] p_o
);

  always_comb begin
    p_o = a_i * b_i;
  end

endmodule

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
  import fmul_pkg::*;
#(
  parameter int PASSES = 4,
  localparam int PW    = $clog2(PASSES),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          slow_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [PW-1:0] pass_o,
  output logic          acc_en_o,
  output logic          fin_en_o
);

  run_state_e    state_q, state_d;
  logic          slow_q, slow_d;
  logic [CW-1:0] step_q, step_d;
  logic          pass_half_done;
  logic          last_pass;

  always_comb begin
    busy_o         = (state_q == ST_RUN);
    accept_o       = start_i & ~busy_o;
    pass_o         = slow_q ? step_q[PW:1] : step_q[PW-1:0];
    pass_half_done = ~slow_q | step_q[0];
    last_pass      = &pass_o;
    fin_en_o       = busy_o & pass_half_done & last_pass;
    acc_en_o       = busy_o & pass_half_done & ~last_pass;
  end

  always_comb begin
    state_d = state_q;
    slow_d  = slow_q;
    step_d  = step_q;
    if (accept_o) begin
      state_d = ST_RUN;
      slow_d  = slow_i;
      step_d  = '0;
    end else if (fin_en_o) begin
      state_d = ST_IDLE;
      step_d  = '0;
    end else if (busy_o) begin
      step_d  = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slow_q  <= 1'b0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      slow_q  <= slow_d;
      step_q  <= step_d;
    end
  end

endmodule

// File: rtl/fmul_datapath.sv
module fmul_datapath #(
  parameter int DW       = fmul_pkg::FMUL_DW,
  parameter int BW       = fmul_pkg::FMUL_BW,
  parameter int IW       = fmul_pkg::FMUL_IW,
  parameter int SKIP_IDX = fmul_pkg::FMUL_SKIP_IDX,
  localparam int NB      = DW / BW,
  localparam int HW      = $clog2(NB),
  localparam int PW      = 2 * HW,
  localparam int AW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [PW-1:0] pass_i,
  input  logic          acc_en_i,
  input  logic          fin_en_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] r6_i,
  input  logic [IW-1:0] dst_i,
  output logic          done_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] result_o,
  output logic          flag_s_o,
  output logic          flag_z_o,
  output logic          flag_cy_o
);

  localparam logic [IW-1:0] SKIP_CODE = IW'(SKIP_IDX);

  // captured operand magnitudes, sign relation and destination
  logic [DW-1:0] mag_a_q, mag_a_d;
  logic [DW-1:0] mag_b_q, mag_b_d;
  logic          neg_q,   neg_d;
  logic [IW-1:0] dst_q;

  // byte slices of the magnitudes
  logic [BW-1:0] a_byte [NB];
  logic [BW-1:0] b_byte [NB];

  for (genvar k = 0; k < NB; k++) begin : g_slice
    assign a_byte[k] = mag_a_q[k*BW +: BW];
    assign b_byte[k] = mag_b_q[k*BW +: BW];
  end

  logic [HW-1:0]   sel_a, sel_b;
  logic [HW:0]     weight;
  logic [BW-1:0]   mul_a, mul_b;
  logic [2*BW-1:0] pp;
  logic [AW-1:0]   pp_shifted;
  logic [AW-1:0]   acc_q, acc_d;
  logic [AW-1:0]   mag_sum;
  logic [AW-1:0]   product;

  always_comb begin
    sel_a  = pass_i[HW-1:0];
    sel_b  = pass_i[PW-1:HW];
    weight = {1'b0, sel_a} + {1'b0, sel_b};
    mul_a  = a_byte[sel_a];
    mul_b  = b_byte[sel_b];
  end

  fmul_byte_mul #(.BW(BW)) i_byte_mul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (pp)
  );

  always_comb begin
    pp_shifted = {{(AW-2*BW){1'b0}}, pp} << (weight * BW);
    mag_sum    = acc_q + pp_shifted;
    product    = neg_q ? (~mag_sum + 1'b1) : mag_sum;
  end

  // operand capture
  always_comb begin
    mag_a_d = src_i[DW-1] ? (~src_i + 1'b1) : src_i;
    mag_b_d = r6_i[DW-1]  ? (~r6_i  + 1'b1) : r6_i;
    neg_d   = src_i[DW-1] ^ r6_i[DW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_a_q <= '0;
      mag_b_q <= '0;
      neg_q   <= 1'b0;
      dst_q   <= '0;
    end else if (accept_i) begin
      mag_a_q <= mag_a_d;
      mag_b_q <= mag_b_d;
      neg_q   <= neg_d;
      dst_q   <= dst_i;
    end
  end

  // accumulator
  always_comb begin
    acc_d = acc_q;
    if (accept_i) begin
      acc_d = '0;
    end else if (acc_en_i) begin
      acc_d = mag_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // result and flags, updated only on finish
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      flag_s_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_cy_o <= 1'b0;
      wr_idx_o  <= '0;
    end else if (fin_en_i) begin
      result_o  <= product[AW-1:DW];
      flag_s_o  <= product[AW-1];
      flag_z_o  <= (product[AW-1:DW] == '0);
      flag_cy_o <= product[DW-1];
      wr_idx_o  <= dst_q;
    end
  end

  // strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
    end else begin
      done_o  <= fin_en_i;
      wr_en_o <= fin_en_i & (dst_q != SKIP_CODE);
    end
  end

endmodule

// File: rtl/sfrac_mul_unit.sv
module sfrac_mul_unit
  import fmul_pkg::*;
#(
  parameter int DW       = FMUL_DW,
  parameter int BW       = FMUL_BW,
  parameter int IW       = FMUL_IW,
  parameter int SKIP_IDX = FMUL_SKIP_IDX,
  localparam int NB      = DW / BW,
  localparam int PASSES  = NB * NB,
  localparam int PW      = $clog2(PASSES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] src_op_i,
  input  logic [DW-1:0] r6_op_i,
  input  logic [IW-1:0] dst_idx_i,
  input  logic          slow_cfg_i,
  output logic          done_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] result_o,
  output logic          flag_s_o,
  output logic          flag_z_o,
  output logic          flag_cy_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  logic          accept;
  logic          busy;
  logic [PW-1:0] pass;
  logic          acc_en;
  logic          fin_en;

  fmul_ctrl #(.PASSES(PASSES)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .slow_i   (slow_cfg_i),
    .accept_o (accept),
    .busy_o   (busy),
    .pass_o   (pass),
    .acc_en_o (acc_en),
    .fin_en_o (fin_en)
  );

  fmul_datapath #(
    .DW       (DW),
    .BW       (BW),
    .IW       (IW),
    .SKIP_IDX (SKIP_IDX)
  ) i_datapath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept_i  (accept),
    .pass_i    (pass),
    .acc_en_i  (acc_en),
    .fin_en_i  (fin_en),
    .src_i     (src_op_i),
    .r6_i      (r6_op_i),
    .dst_i     (dst_idx_i),
    .done_o    (done_o),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .result_o  (result_o),
    .flag_s_o  (flag_s_o),
    .flag_z_o  (flag_z_o),
    .flag_cy_o (flag_cy_o)
  );

endmodule

// File: rtl/fmul_chk.sv
module fmul_chk #(
  parameter int DW       = 16,
  parameter int IW       = 4,
  parameter int SKIP_IDX = 4,
  parameter int PASSES   = 4,
  localparam int LCW     = $clog2(2 * PASSES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy,
  input logic          slow_cfg_i,
  input logic          done_o,
  input logic          wr_en_o,
  input logic [IW-1:0] wr_idx_o,
  input logic [DW-1:0] result_o,
  input logic          flag_s_o,
  input logic          flag_z_o,
  input logic          flag_cy_o
);

  localparam logic [IW-1:0]  SKIP_CODE = IW'(SKIP_IDX);
  localparam logic [LCW-1:0] LAT_FAST  = LCW'(PASSES);
  localparam logic [LCW-1:0] LAT_SLOW  = LCW'(2 * PASSES);

  logic [LCW-1:0] lat_cnt_q;
  logic [LCW-1:0] lat_exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt_q <= '0;
      lat_exp_q <= '0;
    end else if (start_i && !busy) begin
      lat_cnt_q <= '0;
      lat_exp_q <= slow_cfg_i ? LAT_SLOW : LAT_FAST;
    end else if (busy) begin
      lat_cnt_q <= lat_cnt_q + 1'b1;
    end
  end

  // R4 R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt_q == lat_exp_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  wr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);

  // R6
  skip_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wr_idx_o == SKIP_CODE) |-> !wr_en_o);

  // R6
  write_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wr_idx_o != SKIP_CODE) |-> wr_en_o);

  // R3
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_s_o == result_o[DW-1]));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_z_o == (result_o == '0)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(flag_cy_o) && $stable(flag_z_o)));

endmodule

bind sfrac_mul_unit fmul_chk #(
  .DW       (DW),
  .IW       (IW),
  .SKIP_IDX (SKIP_IDX),
  .PASSES   (PASSES)
) i_fmul_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_i    (start_i),
  .busy       (busy),
  .slow_cfg_i (slow_cfg_i),
  .done_o     (done_o),
  .wr_en_o    (wr_en_o),
  .wr_idx_o   (wr_idx_o),
  .result_o   (result_o),
  .flag_s_o   (flag_s_o),
  .flag_z_o   (flag_z_o),
  .flag_cy_o  (flag_cy_o)
);

// File: tb/test_sfrac_mul_unit.sv
module test_sfrac_mul_unit;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] src_op_i;
  logic [15:0] r6_op_i;
  logic [3:0]  dst_idx_i;
  logic        slow_cfg_i;
  logic        done_o;
  logic        wr_en_o;
  logic [3:0]  wr_idx_o;
  logic [15:0] result_o;
  logic        flag_s_o;
  logic        flag_z_o;
  logic        flag_cy_o;

  int n_chk;
  int n_fail;

  sfrac_mul_unit i_sfrac_mul_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .src_op_i   (src_op_i),
    .r6_op_i    (r6_op_i),
    .dst_idx_i  (dst_idx_i),
    .slow_cfg_i (slow_cfg_i),
    .done_o     (done_o),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .result_o   (result_o),
    .flag_s_o   (flag_s_o),
    .flag_z_o   (flag_z_o),
    .flag_cy_o  (flag_cy_o)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {a, b, dst, slow}
  localparam int NVEC = 10;
  localparam logic [36:0] VEC [NVEC] = '{
    {16'h4AAA, 16'hDAAB, 4'd2,  1'b0},
    {16'h8000, 16'h8000, 4'd1,  1'b1},
    {16'h8000, 16'h7FFF, 4'd3,  1'b0},
    {16'h7FFF, 16'h7FFF, 4'd0,  1'b1},
    {16'h0000, 16'h1234, 4'd5,  1'b0},
    {16'hFFFF, 16'h0001, 4'd4,  1'b0},
    {16'hFFFF, 16'hFFFF, 4'd15, 1'b1},
    {16'h1234, 16'h5678, 4'd7,  1'b0},
    {16'h8000, 16'h0001, 4'd9,  1'b1},
    {16'h0100, 16'h0100, 4'd6,  1'b0}
  };

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] d, input logic s);
    src_op_i   = a;
    r6_op_i    = b;
    dst_idx_i  = d;
    slow_cfg_i = s;
    start_i    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  // at the negedge after the accepting edge; waits to the done cycle and checks
  task automatic wait_and_check(input logic [15:0] a, input logic [15:0] b,
                                input logic [3:0] d, input logic s);
    logic signed [15:0] sa;
    logic signed [15:0] sb;
    logic signed [31:0] p;
    int lat;
    sa  = a;
    sb  = b;
    p   = sa * sb;
    lat = s ? 8 : 4;
    repeat (lat - 1) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, s ? "R5 early done" : "R4 early done", 32'(done_o), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b1, s ? "R5 done" : "R4 done", 32'(done_o), 32'd1);
    chk(result_o == p[31:16], "R1 result", 32'(result_o), 32'(p[31:16]));
    chk(flag_cy_o == p[15], "R2 carry", 32'(flag_cy_o), 32'(p[15]));
    chk(flag_s_o == p[31], "R3 sign", 32'(flag_s_o), 32'(p[31]));
    chk(flag_z_o == (p[31:16] == 16'h0), "R3 zero", 32'(flag_z_o),
        32'(p[31:16] == 16'h0));
    chk(wr_en_o == (d != 4'd4), "R6 write enable", 32'(wr_en_o), 32'(d != 4'd4));
    chk(wr_idx_o == d, "R6 index", 32'(wr_idx_o), 32'(d));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [36:0] v;
    int extra;
    n_chk      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    src_op_i   = '0;
    r6_op_i    = '0;
    dst_idx_i  = '0;
    slow_cfg_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({done_o, wr_en_o, result_o, wr_idx_o, flag_s_o, flag_z_o, flag_cy_o} == '0,
        "R10 in reset", 32'(result_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10
    chk({done_o, wr_en_o, result_o, wr_idx_o, flag_s_o, flag_z_o, flag_cy_o} == '0,
        "R10 after reset", 32'(result_o), 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      issue(v[36:21], v[20:5], v[4:1], v[0]);
      wait_and_check(v[36:21], v[20:5], v[4:1], v[0]);
      @(negedge clk);
      // R7 one-cycle strobes
      chk(done_o == 1'b0 && wr_en_o == 1'b0, "R7 strobe width",
          32'({done_o, wr_en_o}), 32'd0);
    end

    // R7 hold between done cycles
    repeat (5) @(negedge clk);
    chk(result_o == 16'h0001, "R7 result hold", 32'(result_o), 32'h0001);

    // R8 start held through busy cycles and the done edge is ignored
    issue(16'h4AAA, 16'hDAAB, 4'd8, 1'b0);
    src_op_i  = 16'h7FFF;
    r6_op_i   = 16'h7FFF;
    dst_idx_i = 4'd11;
    start_i   = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 busy start", 32'(done_o), 32'd0);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1 && result_o == 16'hF51C && flag_cy_o && flag_s_o,
        "R8 original result", 32'(result_o), 32'hF51C);
    chk(wr_idx_o == 4'd8, "R8 original index", 32'(wr_idx_o), 32'd8);
    extra = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk(extra == 0, "R8 no extra done", 32'(extra), 32'd0);

    // R9 inputs change after acceptance
    issue(16'h1234, 16'h5678, 4'd3, 1'b1);
    src_op_i   = 16'h8000;
    r6_op_i    = 16'h0002;
    dst_idx_i  = 4'd4;
    slow_cfg_i = 1'b0;
    wait_and_check(16'h1234, 16'h5678, 4'd3, 1'b1);
    chk(result_o == 16'h0626, "R9 captured operands", 32'(result_o), 32'h0626);

    // R8 back-to-back: start accepted in the done cycle
    @(negedge clk);
    issue(16'h4AAA, 16'hDAAB, 4'd4, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(done_o && !wr_en_o && result_o == 16'hF51C, "R6 skip index 4",
        32'({wr_en_o, result_o}), 32'h0000F51C);
    src_op_i   = 16'h8000;
    r6_op_i    = 16'h8000;
    dst_idx_i  = 4'd12;
    slow_cfg_i = 1'b0;
    start_i    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    wait_and_check(16'h8000, 16'h8000, 4'd12, 1'b0);
    chk(result_o == 16'h4000 && !flag_cy_o, "R8 second result", 32'(result_o),
        32'h4000);

    repeat (3) @(negedge clk);
    report();
    $finish;
  end

endmodule